// File: doc/BRIEF.md
# Error-Correcting Data FIFO with Receive Watermark

This block is a synchronous first-in first-out buffer that holds 32-bit words moving between a card-side engine and a bus-side engine. Every stored word carries a Hamming code with an added overall parity bit, so a single flipped bit is repaired on the way out and two flipped bits are reported as uncorrectable. A fill count is always visible. A receive data-request output stays high while the count is above a programmable watermark, which tells a consumer to keep draining.

Both the write side and the read side have test inputs that corrupt one or two data bits of a word in flight. A management agent uses them to prove the checking logic works. These inputs, and the checking itself, act only while the ECC enable is high. Before checking is switched on for the first time, an initialisation sweep writes a zero word with valid check bits into every location. The sweep also empties the FIFO, so that stale contents cannot produce false error reports.

Pops are registered. A word popped in one cycle appears on the read port in the next cycle, together with its valid strobe and any error pulse.

Top module: `secded_fifo`

## Requirements
- R1: Words leave in the order they entered. `count_o` holds the number of stored words, from 0 to DEPTH (1024 by default, 32-bit words). `full_o` is high at DEPTH and `empty_o` is high at 0. A push and a pop accepted in the same cycle leave the count unchanged.
- R2: A push while full is ignored. In the next cycle `overflow_o` is high for exactly one cycle. This also holds when a pop is accepted in the same cycle.
- R3: A pop while empty is ignored. In the next cycle `underflow_o` is high for exactly one cycle. A push in the same cycle is still accepted.
- R4: After an accepted pop, `pop_valid_o` is high for one cycle in the next cycle, and `pop_data_o` carries the oldest word.
- R5: `rx_dreq_o` is high exactly while `count_o` is strictly greater than `rx_wmark_i`.
- R6: Write-side injection acts on the word being pushed, and only while `ecc_en_i` is high at the push. `wr_inj_sbe_i` inverts stored data bit 0. `wr_inj_dbe_i` inverts data bits 0 and 1. If both are high, the double-bit form applies.
- R7: Read-side injection acts in the same way on the word being popped, and only while `ecc_en_i` is high at the pop. Its inversions combine with any stored ones by exclusive-or, so the same bit inverted on both sides cancels.
- R8: With `ecc_en_i` high at the pop, a word with one inverted bit is delivered corrected. `ecc_corr_o` is high for one cycle alongside `pop_valid_o`.
- R9: With `ecc_en_i` high at the pop, a word with two inverted bits raises `ecc_uncorr_o` for one cycle alongside `pop_valid_o`. The data is delivered uncorrected, with both inversions visible.
- R10: With `ecc_en_i` low at the pop, the stored data bits are delivered as they are and neither error pulse rises.
- R11: When `init_i` is high while no sweep is running, the FIFO empties at the next edge. `init_busy_o` is then high for exactly DEPTH cycles while a zero codeword is written to every location. Pushes and pops presented in the starting cycle or while busy are ignored and raise no flags.
- R12: During and directly after reset the FIFO is empty, the count is 0, and the data request, busy flag, valid strobe and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ecc_en_i | input | 1 | Enables checking and error injection |
| init_i | input | 1 | Starts the initialisation sweep |
| init_busy_o | output | 1 | Sweep in progress |
| push_i | input | 1 | Write request |
| push_data_i | input | 32 | Write data |
| wr_inj_sbe_i | input | 1 | Write-side single-bit injection |
| wr_inj_dbe_i | input | 1 | Write-side double-bit injection |
| full_o | output | 1 | FIFO holds DEPTH words |
| overflow_o | output | 1 | One-cycle pulse after a rejected push |
| pop_i | input | 1 | Read request |
| rd_inj_sbe_i | input | 1 | Read-side single-bit injection |
| rd_inj_dbe_i | input | 1 | Read-side double-bit injection |
| empty_o | output | 1 | FIFO holds no words |
| underflow_o | output | 1 | One-cycle pulse after a rejected pop |
| pop_valid_o | output | 1 | Read data valid |
| pop_data_o | output | 32 | Read data |
| ecc_corr_o | output | 1 | Single-bit error corrected on this word |
| ecc_uncorr_o | output | 1 | Double-bit error detected on this word |
| count_o | output | 11 | Fill count |
| rx_wmark_i | input | 11 | Receive watermark |
| rx_dreq_o | output | 1 | Count above watermark |

## Verification
Write-side injection on an incoming word and read-side checking of an outgoing word can happen in the same cycle. The bench provokes this by pushing with double-bit injection while popping an earlier word under single-bit read injection. It also pushes and pops together at the full and empty limits, where one request is accepted and the other is rejected. In every cycle a queue-based reference model in the bench predicts the count, the flags, the data request, the delivered word and the error pulses, and each of these is compared against the outputs. Words written with injection and read with and without checking enabled show whether inversions are applied, cancelled or ignored as the enable demands.

// File: rtl/secded_fifo_pkg.sv
package secded_fifo_pkg;

  typedef enum logic [1:0] {
    DEC_CLEAN = 2'd0,
    DEC_FIXED = 2'd1,
    DEC_FATAL = 2'd2
  } dec_stat_e;

  // Hamming check bits needed for dw data bits (overall parity excluded)
  function automatic int chk_bits(input int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  // codeword position of data bit i: i-th non power of two, counting from 1
  function automatic int data_pos(input int i);
    int p, n;
    p = 0;
    n = -1;
    while (n < i) begin
      p++;
      if ((p & (p - 1)) != 0) n++;
    end
    return p;
  endfunction

  // positions covered by check bit k; codewords up to 64 bits
  function automatic logic [63:0] cover_mask(input int k);
    logic [63:0] m;
    m = '0;
    for (int p = 1; p < 64; p++) m[p] = ((p >> k) & 1) != 0;
    return m;
  endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_fifo_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int PW     = chk_bits(DATA_W),
  localparam int CW     = DATA_W + PW + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CW-1:0]     code_o
);

  always_comb begin
    logic [63:0] m;
    m      = '0;
    code_o = '0;
    for (int i = 0; i < DATA_W; i++) code_o[data_pos(i)] = data_i[i];
    for (int k = 0; k < PW; k++) begin
      m = cover_mask(k);
      code_o[1 << k] = ^(code_o & m[CW-1:0]);
    end
    code_o[0] = ^code_o;  // overall parity, bit 0 still zero here
  end

endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_fifo_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int PW     = chk_bits(DATA_W),
  localparam int CW     = DATA_W + PW + 1
) (
  input  logic              chk_i,
  input  logic [CW-1:0]     code_i,
  output logic [DATA_W-1:0] data_o,
  output dec_stat_e         stat_o
);

  logic [PW-1:0] syn;
  logic          ovr;
  logic [CW-1:0] fixed;

  always_comb begin
    logic [63:0] m;
    m = '0;
    for (int k = 0; k < PW; k++) begin
      m = cover_mask(k);
      syn[k] = ^(code_i & m[CW-1:0]);
    end
    ovr    = ^code_i;
    fixed  = code_i;
    stat_o = DEC_CLEAN;
    if (chk_i) begin
      if (ovr) begin
        // odd weight: single error at position syn (0 = parity bit itself)
        if (int'(syn) < CW) begin
          stat_o = DEC_FIXED;
          for (int p = 0; p < CW; p++)
            if (int'(syn) == p) fixed[p] = ~code_i[p];
        end else begin
          stat_o = DEC_FATAL;
        end
      end else if (syn != '0) begin
        stat_o = DEC_FATAL;
      end
    end
    data_o = '0;
    for (int i = 0; i < DATA_W; i++) data_o[i] = fixed[data_pos(i)];
  end

endmodule

// File: rtl/secded_fifo_ram.sv
module secded_fifo_ram #(
  parameter  int WIDTH = 39,
  parameter  int DEPTH = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             re_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (re_i) rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/secded_fifo_ctrl.sv
module secded_fifo_ctrl #(
  parameter  int DEPTH = 1024,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             push_i,
  input  logic             pop_i,
  output logic             push_ok_o,
  output logic             pop_ok_o,
  output logic [AW-1:0]    waddr_o,
  output logic [AW-1:0]    raddr_o,
  output logic             sweep_o,
  output logic [CNT_W-1:0] count_o,
  output logic             overflow_o,
  output logic             underflow_o
);

  logic [AW-1:0]    wp_q, rp_q, sweep_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, ovf_q, udf_q;
  logic             idle, full, empty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] a);
    return (a == AW'(DEPTH - 1)) ? '0 : a + AW'(1);
  endfunction

  // the init start cycle counts as busy for requests
  assign idle      = !busy_q && !init_i;
  assign full      = cnt_q == CNT_W'(DEPTH);
  assign empty     = cnt_q == '0;
  assign push_ok_o = idle && push_i && !full;
  assign pop_ok_o  = idle && pop_i && !empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q    <= '0;
      rp_q    <= '0;
      sweep_q <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      ovf_q   <= 1'b0;
      udf_q   <= 1'b0;
    end else begin
      ovf_q <= idle && push_i && full;
      udf_q <= idle && pop_i && empty;
      if (busy_q) begin
        sweep_q <= bump(sweep_q);
        if (sweep_q == AW'(DEPTH - 1)) busy_q <= 1'b0;
      end else if (init_i) begin
        busy_q  <= 1'b1;
        sweep_q <= '0;
        wp_q    <= '0;
        rp_q    <= '0;
        cnt_q   <= '0;
      end else begin
        if (push_ok_o) wp_q <= bump(wp_q);
        if (pop_ok_o)  rp_q <= bump(rp_q);
        cnt_q <= cnt_q + CNT_W'(push_ok_o) - CNT_W'(pop_ok_o);
      end
    end
  end

  assign waddr_o     = busy_q ? sweep_q : wp_q;
  assign raddr_o     = rp_q;
  assign sweep_o     = busy_q;
  assign count_o     = cnt_q;
  assign overflow_o  = ovf_q;
  assign underflow_o = udf_q;

endmodule

// File: rtl/secded_fifo.sv
module secded_fifo
  import secded_fifo_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int DEPTH  = 1024,
  localparam int PW     = chk_bits(DATA_W),
  localparam int CW     = DATA_W + PW + 1,
  localparam int AW     = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ecc_en_i,
  input  logic              init_i,
  output logic              init_busy_o,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              wr_inj_sbe_i,
  input  logic              wr_inj_dbe_i,
  output logic              full_o,
  output logic              overflow_o,
  input  logic              pop_i,
  input  logic              rd_inj_sbe_i,
  input  logic              rd_inj_dbe_i,
  output logic              empty_o,
  output logic              underflow_o,
  output logic              pop_valid_o,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              ecc_corr_o,
  output logic              ecc_uncorr_o,
  output logic [CNT_W-1:0]  count_o,
  input  logic [CNT_W-1:0]  rx_wmark_i,
  output logic              rx_dreq_o
);

  localparam int P0 = data_pos(0);
  localparam int P1 = data_pos(1);

  logic          push_ok, pop_ok, sweep;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] enc_code, wr_flip, rd_flip, wdata, rdata;
  logic [CW-1:0] rd_flip_q;
  logic          valid_q, chk_q;
  dec_stat_e     stat;

  function automatic logic [CW-1:0] flip_mask(input logic sbe, input logic dbe);
    logic [CW-1:0] m;
    m = '0;
    if (dbe) begin
      m[P0] = 1'b1;
      m[P1] = 1'b1;
    end else if (sbe) begin
      m[P0] = 1'b1;
    end
    return m;
  endfunction

  secded_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_i      (init_i),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .push_ok_o   (push_ok),
    .pop_ok_o    (pop_ok),
    .waddr_o     (waddr),
    .raddr_o     (raddr),
    .sweep_o     (sweep),
    .count_o     (count_o),
    .overflow_o  (overflow_o),
    .underflow_o (underflow_o)
  );

  secded_enc #(.DATA_W(DATA_W)) u_enc (
    .data_i (push_data_i),
    .code_o (enc_code)
  );

  assign wr_flip = ecc_en_i ? flip_mask(wr_inj_sbe_i, wr_inj_dbe_i) : '0;
  assign rd_flip = ecc_en_i ? flip_mask(rd_inj_sbe_i, rd_inj_dbe_i) : '0;
  // all-zero vector is a valid codeword of this linear code
  assign wdata   = sweep ? '0 : (enc_code ^ wr_flip);

  secded_fifo_ram #(.WIDTH(CW), .DEPTH(DEPTH)) u_ram (
    .clk_i   (clk_i),
    .we_i    (push_ok | sweep),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .re_i    (pop_ok),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  // read controls captured with the pop, aligned to the RAM output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      chk_q     <= 1'b0;
      rd_flip_q <= '0;
    end else begin
      valid_q <= pop_ok;
      if (pop_ok) begin
        chk_q     <= ecc_en_i;
        rd_flip_q <= rd_flip;
      end
    end
  end

  secded_dec #(.DATA_W(DATA_W)) u_dec (
    .chk_i  (chk_q),
    .code_i (rdata ^ rd_flip_q),
    .data_o (pop_data_o),
    .stat_o (stat)
  );

  assign pop_valid_o  = valid_q;
  assign ecc_corr_o   = valid_q && (stat == DEC_FIXED);
  assign ecc_uncorr_o = valid_q && (stat == DEC_FATAL);
  assign init_busy_o  = sweep;
  assign full_o       = count_o == CNT_W'(DEPTH);
  assign empty_o      = count_o == '0;
  assign rx_dreq_o    = count_o > rx_wmark_i;

endmodule

// File: rtl/secded_fifo_chk.sv
module secded_fifo_chk #(
  parameter int DEPTH = 1024,
  parameter int CNT_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ecc_en_i,
  input logic             push_i,
  input logic             pop_i,
  input logic [CNT_W-1:0] count_o,
  input logic             full_o,
  input logic             empty_o,
  input logic             rx_dreq_o,
  input logic             init_busy_o,
  input logic             pop_valid_o,
  input logic             ecc_corr_o,
  input logic             ecc_uncorr_o,
  input logic             overflow_o,
  input logic             underflow_o
);

  assert_count_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_o) <= DEPTH);

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> $past(push_i) && $past(full_o));

  assert_no_underflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> $past(pop_i) && $past(empty_o));

  assert_valid_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_valid_o |-> $past(pop_i) && !$past(empty_o));

  assert_dreq_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !rx_dreq_o);

  assert_corr_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_corr_o |-> pop_valid_o && !ecc_uncorr_o);

  assert_uncorr_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_uncorr_o |-> pop_valid_o);

  assert_quiet_unchecked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_valid_o && !$past(ecc_en_i)) |-> !ecc_corr_o && !ecc_uncorr_o);

  assert_sweep_empty_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_busy_o |-> empty_o && !pop_valid_o);

endmodule

bind secded_fifo secded_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ecc_en_i     (ecc_en_i),
  .push_i       (push_i),
  .pop_i        (pop_i),
  .count_o      (count_o),
  .full_o       (full_o),
  .empty_o      (empty_o),
  .rx_dreq_o    (rx_dreq_o),
  .init_busy_o  (init_busy_o),
  .pop_valid_o  (pop_valid_o),
  .ecc_corr_o   (ecc_corr_o),
  .ecc_uncorr_o (ecc_uncorr_o),
  .overflow_o   (overflow_o),
  .underflow_o  (underflow_o)
);

// File: tb/sim_secded_fifo.sv
`timescale 1ns/1ps
module sim_secded_fifo;

  localparam int DEPTH = 1024;
  localparam int CNT_W = 11;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             ecc_en_i, init_i, push_i, pop_i;
  logic             wr_inj_sbe_i, wr_inj_dbe_i, rd_inj_sbe_i, rd_inj_dbe_i;
  logic [31:0]      push_data_i;
  logic [CNT_W-1:0] rx_wmark_i;
  logic             init_busy_o, full_o, overflow_o, empty_o, underflow_o;
  logic             pop_valid_o, ecc_corr_o, ecc_uncorr_o, rx_dreq_o;
  logic [31:0]      pop_data_o;
  logic [CNT_W-1:0] count_o;

  always #4 clk_i = ~clk_i;  // 125 MHz

  secded_fifo u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .ecc_en_i(ecc_en_i), .init_i(init_i),
    .init_busy_o(init_busy_o), .push_i(push_i), .push_data_i(push_data_i),
    .wr_inj_sbe_i(wr_inj_sbe_i), .wr_inj_dbe_i(wr_inj_dbe_i), .full_o(full_o),
    .overflow_o(overflow_o), .pop_i(pop_i), .rd_inj_sbe_i(rd_inj_sbe_i),
    .rd_inj_dbe_i(rd_inj_dbe_i), .empty_o(empty_o), .underflow_o(underflow_o),
    .pop_valid_o(pop_valid_o), .pop_data_o(pop_data_o), .ecc_corr_o(ecc_corr_o),
    .ecc_uncorr_o(ecc_uncorr_o), .count_o(count_o), .rx_wmark_i(rx_wmark_i),
    .rx_dreq_o(rx_dreq_o)
  );

  // reference model state
  logic [31:0] q_data[$];
  logic [1:0]  q_mask[$];
  int          busy_left = 0;
  logic        e_valid, e_corr, e_unc, e_ovf, e_udf;
  logic [31:0] e_data;
  string       e_tag;
  int          n_chk = 0, n_fail = 0, cycles = 0;
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [1:0] inj(input logic sbe, input logic dbe);
    return dbe ? 2'b11 : (sbe ? 2'b01 : 2'b00);
  endfunction

  function automatic logic [31:0] pat();
    seed = seed * 32'h0019_660D + 32'h3C6E_F35F;
    return seed;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model();
    logic        was_full, was_empty;
    logic [31:0] w;
    logic [1:0]  m, rm, t;
    int          pc;
    e_valid = 0; e_corr = 0; e_unc = 0; e_ovf = 0; e_udf = 0;
    if (busy_left > 0) begin
      busy_left--;
    end else if (init_i) begin
      busy_left = DEPTH;
      q_data.delete();
      q_mask.delete();
    end else begin
      was_full  = q_data.size() == DEPTH;
      was_empty = q_data.size() == 0;
      if (pop_i) begin
        if (was_empty) e_udf = 1;
        else begin
          w  = q_data.pop_front();
          m  = q_mask.pop_front();
          rm = ecc_en_i ? inj(rd_inj_sbe_i, rd_inj_dbe_i) : 2'b00;
          t  = m ^ rm;
          pc = int'(t[0]) + int'(t[1]);
          e_valid = 1;
          e_data  = w ^ {30'b0, t};
          if (!ecc_en_i) e_tag = "R10";
          else if (pc == 2) begin e_unc = 1; e_tag = "R9"; end
          else if (pc == 1) begin e_corr = 1; e_data = w; e_tag = "R8"; end
          else if (m != 0 || rm != 0) e_tag = "R7";
          else e_tag = "R4";
        end
      end
      if (push_i) begin
        if (was_full) e_ovf = 1;
        else begin
          q_data.push_back(push_data_i);
          q_mask.push_back(ecc_en_i ? inj(wr_inj_sbe_i, wr_inj_dbe_i) : 2'b00);
        end
      end
    end
  endtask

  task automatic compare();
    chk(int'(count_o) == q_data.size(), "R1", "count", 32'(count_o), 32'(q_data.size()));
    chk(full_o == (q_data.size() == DEPTH), "R1", "full", 32'(full_o), 32'(q_data.size() == DEPTH));
    chk(empty_o == (q_data.size() == 0), "R1", "empty", 32'(empty_o), 32'(q_data.size() == 0));
    chk(rx_dreq_o == (q_data.size() > int'(rx_wmark_i)), "R5", "dreq",
        32'(rx_dreq_o), 32'(q_data.size() > int'(rx_wmark_i)));
    chk(init_busy_o == (busy_left > 0), "R11", "busy", 32'(init_busy_o), 32'(busy_left > 0));
    chk(pop_valid_o == e_valid, "R4", "valid", 32'(pop_valid_o), 32'(e_valid));
    if (e_valid) chk(pop_data_o == e_data, e_tag, "data", pop_data_o, e_data);
    chk(ecc_corr_o == e_corr, "R8", "corr", 32'(ecc_corr_o), 32'(e_corr));
    chk(ecc_uncorr_o == e_unc, "R9", "uncorr", 32'(ecc_uncorr_o), 32'(e_unc));
    chk(overflow_o == e_ovf, "R2", "overflow", 32'(overflow_o), 32'(e_ovf));
    chk(underflow_o == e_udf, "R3", "underflow", 32'(underflow_o), 32'(e_udf));
  endtask

  task automatic cyc(input logic ps, input logic [31:0] d, input logic pp,
                     input logic ws = 0, input logic wd = 0,
                     input logic rs = 0, input logic rdb = 0, input logic ini = 0);
    push_i = ps; push_data_i = d; pop_i = pp;
    wr_inj_sbe_i = ws; wr_inj_dbe_i = wd;
    rd_inj_sbe_i = rs; rd_inj_dbe_i = rdb; init_i = ini;
    @(posedge clk_i);
    model();
    @(negedge clk_i);
    compare();
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles == 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; ecc_en_i = 1; init_i = 0; push_i = 0; pop_i = 0;
    push_data_i = '0; wr_inj_sbe_i = 0; wr_inj_dbe_i = 0;
    rd_inj_sbe_i = 0; rd_inj_dbe_i = 0; rx_wmark_i = 11'd4;
    repeat (3) @(negedge clk_i);
    // R12 reset state
    chk(count_o == 0 && empty_o && !full_o, "R12", "reset count/empty", 32'(count_o), 0);
    chk(!rx_dreq_o && !init_busy_o && !pop_valid_o, "R12", "reset strobes",
        {29'b0, rx_dreq_o, init_busy_o, pop_valid_o}, 0);
    chk(!ecc_corr_o && !ecc_uncorr_o && !overflow_o && !underflow_o, "R12", "reset pulses",
        {28'b0, ecc_corr_o, ecc_uncorr_o, overflow_o, underflow_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(count_o == 0 && !pop_valid_o && !rx_dreq_o, "R12", "after release", 32'(count_o), 0);

    // R1 R4 R5: ordered fill past the watermark, overlapped push/pop, drain
    for (int i = 0; i < 6; i++) cyc(1, pat(), 0);
    for (int i = 0; i < 4; i++) cyc(1, pat(), 1);
    while (q_data.size() > 0) cyc(0, '0, 1);

    // R3 underflow, with and without a concurrent push
    cyc(0, '0, 1);
    cyc(1, pat(), 1);
    cyc(0, '0, 1);
    cyc(0, '0, 1);

    // R2 fill to DEPTH, overflow alone and with a concurrent pop; R5 at the top
    rx_wmark_i = 11'(DEPTH - 1);
    for (int i = 0; i < DEPTH; i++) cyc(1, pat(), 0);
    cyc(1, pat(), 0);
    cyc(1, pat(), 1);
    cyc(1, pat(), 0);
    rx_wmark_i = 11'd0;
    while (q_data.size() > 0) cyc(0, '0, 1);
    cyc(0, '0, 0);

    // R6 R8 R9 write-side injection; R7 read-side injection and cancel
    rx_wmark_i = 11'd2;
    cyc(1, pat(), 0, 1, 0);
    cyc(1, pat(), 0, 0, 1);
    cyc(1, pat(), 0, 1, 1);
    cyc(1, pat(), 0);
    cyc(1, pat(), 0);
    cyc(1, pat(), 0, 1, 0);
    cyc(0, '0, 1);
    cyc(0, '0, 1);
    cyc(0, '0, 1);
    cyc(0, '0, 1, 0, 0, 1, 0);
    cyc(0, '0, 1, 0, 0, 0, 1);
    cyc(0, '0, 1, 0, 0, 1, 0);
    cyc(0, '0, 0);

    // R6 injection ignored with ECC off at push; R10 no checking with ECC off at pop
    ecc_en_i = 0;
    cyc(1, pat(), 0, 0, 1);
    ecc_en_i = 1;
    cyc(1, pat(), 0, 1, 0);
    cyc(1, pat(), 0, 0, 1);
    cyc(0, '0, 1);
    ecc_en_i = 0;
    cyc(0, '0, 1, 0, 0, 0, 1);
    cyc(0, '0, 1);
    ecc_en_i = 1;
    cyc(0, '0, 0);

    // R6 and R7 in one cycle: push with double injection while popping under read injection
    cyc(1, pat(), 0);
    cyc(1, pat(), 1, 0, 1, 1, 0);
    cyc(1, pat(), 1, 1, 0, 0, 1);
    cyc(0, '0, 1);
    cyc(0, '0, 1);
    cyc(0, '0, 0);

    // R11 init sweep from a non-empty state, requests ignored while busy
    for (int i = 0; i < 3; i++) cyc(1, pat(), 0);
    cyc(1, pat(), 1, 0, 0, 0, 0, 1);
    for (int i = 0; busy_left > 0; i++)
      cyc(i % 3 == 0, pat(), i % 5 == 0, 0, 0, 0, 0, i % 7 == 0);
    cyc(1, pat(), 0);
    cyc(1, pat(), 0);
    cyc(0, '0, 1);
    cyc(0, '0, 1);
    cyc(0, '0, 1);
    cyc(0, '0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule